// File: doc/BRIEF.md
# Dual-Lane 16x16 Multiply-Accumulate Datapath

This block holds two multiply-accumulate lanes that run side by side. Every cycle in which the input bus is marked valid, each lane multiplies its own pair of 16-bit operands and then does one of four things to its own 40-bit accumulator: clears it, loads the product into it, adds the product to it or subtracts the product from it. The 8 bits above the 32-bit product let long sums build up before they wrap. Controls shared by both lanes choose signed or unsigned operands, integer or fractional product format, rounding, saturation and the width of the narrow result.

A decoder upstream drives operands and controls. The block returns three things two cycles later: the raw 40-bit accumulators, a 32-bit narrow result per lane and a sticky overflow flag per lane. The narrow result is either the upper 16-bit half, optionally rounded, or the low 32-bit word. Either can be clamped. Between operations the accumulators and the narrow results hold their values, so the results can be read at any later time.

Top module: `dual_mac`

## Requirements
- R1: `outValid` is high exactly two rising clock edges after a cycle in which `inValid` was high, and low otherwise. The accumulator, narrow result and flag changes for that operation appear in the same cycle.
- R2: The product is the 32-bit product of the two operands. When `isSigned`=1 both operands are two's complement; when `isSigned`=0 both are unsigned. The product is extended to 40 bits in the same signedness.
- R3: When `isFrac`=1 the product is doubled (shifted left by one). With `isSigned`=1 and both operands equal to 0x8000, the product is 0x7FFFFFFF.
- R4: Lane i uses `laneOp[2i+1:2i]` with these codes: 00 sets A=0, 01 sets A=P, 10 sets A=A+P, 11 sets A=A-P. Lane i's operands sit at bits [16i+15:16i] of `opA`/`opB` and its accumulator at bits [40i+39:40i] of `accOut`. The lanes do not affect each other.
- R5: The accumulator arithmetic is modulo 2^40.
- R6: A lane's `ovfFlag` bit is set when an add or subtract leaves the 40-bit range. The range is signed when `isSigned`=1 and unsigned (carry or borrow) when `isSigned`=0. The bit stays set until a cycle with `ovfClr`=1. That clear takes effect two edges later, before any wrap from an operation issued in the same cycle.
- R7: When `wideOut`=0, the narrow result for lane i (`resOut[32i+31:32i]`) is bits [31:16] of the accumulator. If `doRound`=1, 0x8000 is added first (round half up). The result is sign-extended when signed and zero-extended when unsigned.
- R8: When `wideOut`=0 and `doSat`=1, an out-of-range 16-bit value (after rounding) is clamped. In signed mode, a value above 2^31-1 gives 0x7FFF and a value below -2^31 gives 0x8000. In unsigned mode, a value of 2^32 or more gives 0xFFFF.
- R9: When `wideOut`=1, the narrow result is accumulator bits [31:0] and rounding is not applied. With `doSat`=1, a signed result is clamped to 0x7FFFFFFF or 0x80000000, and an unsigned value of 2^32 or more gives 0xFFFFFFFF.
- R10: After reset, `outValid`, both accumulators, both narrow results and both flags are zero.
- R11: A cycle with `inValid`=0 changes no accumulator and no narrow result, whatever the operand, operation and format inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present on the input bus |
| isSigned | input | 1 | 1: two's complement operands and range checks |
| isFrac | input | 1 | 1: fractional product (doubled) |
| doRound | input | 1 | Round the 16-bit extraction half up |
| doSat | input | 1 | Clamp the narrow result on overflow |
| wideOut | input | 1 | 1: 32-bit extraction, 0: 16-bit extraction |
| ovfClr | input | 1 | Clear both sticky overflow flags |
| laneOp | input | 4 | Per-lane operation code, 2 bits per lane |
| opA | input | 32 | First operand, 16 bits per lane |
| opB | input | 32 | Second operand, 16 bits per lane |
| outValid | output | 1 | Results of an operation are present |
| accOut | output | 80 | Accumulators, 40 bits per lane |
| resOut | output | 64 | Narrow results, 32 bits per lane |
| ovfFlag | output | 2 | Sticky overflow flag per lane |

## Verification
The assertions check four behaviours on every cycle. The output valid must follow the input valid by two edges. Accumulators must stay still when no result is produced. An overflow flag may fall only after a clear. A saturated extraction of a clearly out-of-range signed accumulator must give the limit value. Exact product and accumulator values can be shown only by the bench, which runs a reference model over random mixes of operations and formats. The same holds for the fractional corner case, signed and unsigned wrap-around, round-half-up at the boundary and clamping after rounding. Long directed runs of maximum products drive the accumulators through their 40-bit limits.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'b00,
    OP_LOAD  = 2'b01,
    OP_ADD   = 2'b10,
    OP_SUB   = 2'b11
  } macOp_e;

  // strobes handed from control to the lane datapaths
  typedef struct packed {
    logic capEn;        // stage 1: capture product
    logic capSigned;
    logic capFrac;
    logic commitEn;     // stage 2: update accumulator
    logic commitSigned;
    logic ovfClear;
    logic xSigned;      // extraction settings, held between operations
    logic xRound;
    logic xSat;
    logic xWide;
  } macStrobe_t;

endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isSigned,
  input  logic       isFrac,
  input  logic       doRound,
  input  logic       doSat,
  input  logic       wideOut,
  input  logic       ovfClr,
  output macStrobe_t st,
  output logic       outValid
);

  logic v1, c1, s1, r1, sat1, w1;
  logic v2, xs, xr, xsat, xw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1   <= 1'b0;
      c1   <= 1'b0;
      s1   <= 1'b0;
      r1   <= 1'b0;
      sat1 <= 1'b0;
      w1   <= 1'b0;
    end else begin
      v1 <= inValid;
      c1 <= ovfClr;
      if (inValid) begin
        s1   <= isSigned;
        r1   <= doRound;
        sat1 <= doSat;
        w1   <= wideOut;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v2   <= 1'b0;
      xs   <= 1'b0;
      xr   <= 1'b0;
      xsat <= 1'b0;
      xw   <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        xs   <= s1;
        xr   <= r1;
        xsat <= sat1;
        xw   <= w1;
      end
    end
  end

  always_comb begin
    st.capEn        = inValid;
    st.capSigned    = isSigned;
    st.capFrac      = isFrac;
    st.commitEn     = v1;
    st.commitSigned = s1;
    st.ovfClear     = c1;
    st.xSigned      = xs;
    st.xRound       = xr;
    st.xSat         = xsat;
    st.xWide        = xw;
  end

  assign outValid = v2;

endmodule

// File: rtl/dmac_extract.sv
module dmac_extract
  import dmac_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  macStrobe_t                    st,
  input  logic [2*OPW+GUARD-1:0]        acc,
  output logic [2*OPW-1:0]              res
);

  localparam int PRODW = 2 * OPW;
  localparam int ACCW  = PRODW + GUARD;
  localparam logic [ACCW:0] RNDK = (ACCW+1)'(1) << (OPW - 1);

  logic [ACCW:0]        ext, rnd;
  logic [GUARD+1:0]     top16;
  logic [GUARD:0]       top32;
  logic                 ovr16, ovr32;
  logic [OPW-1:0]       half;
  logic [PRODW-1:0]     res16, full;
  logic                 unusedLow;

  always_comb begin
    ext = {st.xSigned & acc[ACCW-1], acc};
    rnd = (st.xRound && !st.xWide) ? ext + RNDK : ext;

    // 16-bit extraction from the upper half of the product field
    top16 = rnd[ACCW:PRODW-1];
    ovr16 = st.xSigned ? !((&top16) || !(|top16)) : (|rnd[ACCW:PRODW]);
    half  = rnd[PRODW-1:OPW];
    if (st.xSat && ovr16) begin
      if (st.xSigned) half = rnd[ACCW] ? {1'b1, {(OPW-1){1'b0}}} : {1'b0, {(OPW-1){1'b1}}};
      else            half = '1;
    end
    res16 = st.xSigned ? {{OPW{half[OPW-1]}}, half} : {{OPW{1'b0}}, half};

    // 32-bit extraction of the low word
    top32 = acc[ACCW-1:PRODW-1];
    ovr32 = st.xSigned ? !((&top32) || !(|top32)) : (|acc[ACCW-1:PRODW]);
    full  = acc[PRODW-1:0];
    if (st.xSat && ovr32) begin
      if (st.xSigned) full = acc[ACCW-1] ? {1'b1, {(PRODW-1){1'b0}}} : {1'b0, {(PRODW-1){1'b1}}};
      else            full = '1;
    end

    res = st.xWide ? full : res16;
  end

  assign unusedLow = &{1'b0, rnd[OPW-1:0]};

endmodule

// File: rtl/dmac_lane.sv
module dmac_lane
  import dmac_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  macStrobe_t             st,
  input  logic [1:0]             opIn,
  input  logic [OPW-1:0]         aIn,
  input  logic [OPW-1:0]         bIn,
  output logic [2*OPW+GUARD-1:0] accQ,
  output logic [2*OPW-1:0]       resQ,
  output logic                   ovfQ
);

  localparam int PRODW = 2 * OPW;
  localparam int ACCW  = PRODW + GUARD;
  localparam int MULW  = 2 * OPW + 2;
  localparam logic [OPW-1:0]  MINOP    = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [ACCW-1:0] FRAC_MAX = {{(GUARD+1){1'b0}}, {(PRODW-1){1'b1}}};

  logic signed [OPW:0]    aExt, bExt;
  logic signed [MULW-1:0] mul;
  logic [ACCW-1:0]        prodW, prodN, prodR, accN;
  macOp_e                 opR;
  logic [ACCW:0]          sumU, difU;
  logic                   sOvfAdd, sOvfSub, wrapN;

  // stage 1: multiply
  assign aExt = {st.capSigned & aIn[OPW-1], aIn};
  assign bExt = {st.capSigned & bIn[OPW-1], bIn};
  assign mul  = aExt * bExt;

  always_comb begin
    prodW = {{(ACCW-MULW){mul[MULW-1]}}, mul};
    if (st.capFrac) begin
      if (st.capSigned && aIn == MINOP && bIn == MINOP) prodN = FRAC_MAX;
      else                                              prodN = prodW << 1;
    end else begin
      prodN = prodW;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodR <= '0;
      opR   <= OP_CLEAR;
    end else if (st.capEn) begin
      prodR <= prodN;
      opR   <= macOp_e'(opIn);
    end
  end

  // stage 2: accumulate
  always_comb begin
    sumU    = {1'b0, accQ} + {1'b0, prodR};
    difU    = {1'b0, accQ} - {1'b0, prodR};
    sOvfAdd = (accQ[ACCW-1] == prodR[ACCW-1]) && (sumU[ACCW-1] != accQ[ACCW-1]);
    sOvfSub = (accQ[ACCW-1] != prodR[ACCW-1]) && (difU[ACCW-1] != accQ[ACCW-1]);
    unique case (opR)
      OP_CLEAR: begin accN = '0;               wrapN = 1'b0; end
      OP_LOAD:  begin accN = prodR;            wrapN = 1'b0; end
      OP_ADD:   begin accN = sumU[ACCW-1:0];
                      wrapN = st.commitSigned ? sOvfAdd : sumU[ACCW]; end
      default:  begin accN = difU[ACCW-1:0];
                      wrapN = st.commitSigned ? sOvfSub : difU[ACCW]; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      if (st.commitEn) accQ <= accN;
      ovfQ <= (ovfQ & ~st.ovfClear) | (st.commitEn & wrapN);
    end
  end

  dmac_extract #(.OPW(OPW), .GUARD(GUARD)) u_extract (
    .st  (st),
    .acc (accQ),
    .res (resQ)
  );

endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dmac_pkg::*;
#(
  parameter int LANES = 2,
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic                              isSigned,
  input  logic                              isFrac,
  input  logic                              doRound,
  input  logic                              doSat,
  input  logic                              wideOut,
  input  logic                              ovfClr,
  input  logic [LANES*2-1:0]                laneOp,
  input  logic [LANES*OPW-1:0]              opA,
  input  logic [LANES*OPW-1:0]              opB,
  output logic                              outValid,
  output logic [LANES*(2*OPW+GUARD)-1:0]    accOut,
  output logic [LANES*2*OPW-1:0]            resOut,
  output logic [LANES-1:0]                  ovfFlag
);

  localparam int PRODW = 2 * OPW;
  localparam int ACCW  = PRODW + GUARD;

  macStrobe_t st;

  dmac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isSigned (isSigned),
    .isFrac   (isFrac),
    .doRound  (doRound),
    .doSat    (doSat),
    .wideOut  (wideOut),
    .ovfClr   (ovfClr),
    .st       (st),
    .outValid (outValid)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dmac_lane #(.OPW(OPW), .GUARD(GUARD)) u_lane (
      .clk  (clk),
      .rstN (rstN),
      .st   (st),
      .opIn (laneOp[i*2 +: 2]),
      .aIn  (opA[i*OPW +: OPW]),
      .bIn  (opB[i*OPW +: OPW]),
      .accQ (accOut[i*ACCW +: ACCW]),
      .resQ (resOut[i*PRODW +: PRODW]),
      .ovfQ (ovfFlag[i])
    );
  end

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int LANES = 2,
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           inValid,
  input logic                           isSigned,
  input logic                           doRound,
  input logic                           doSat,
  input logic                           wideOut,
  input logic                           ovfClr,
  input logic                           outValid,
  input logic [LANES*(2*OPW+GUARD)-1:0] accOut,
  input logic [LANES*2*OPW-1:0]         resOut,
  input logic [LANES-1:0]               ovfFlag
);

  localparam int PRODW = 2 * OPW;
  localparam int ACCW  = PRODW + GUARD;

  logic [1:0] cnt;
  logic vA, vB, cA, cB, sA, sB, rA, rB, tA, tB, wA, wB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      {vA, vB, cA, cB, sA, sB, rA, rB, tA, tB, wA, wB} <= '0;
    end else begin
      if (cnt != 2'd2) cnt <= cnt + 2'd1;
      vA <= inValid;  vB <= vA;
      cA <= ovfClr;   cB <= cA;
      sA <= isSigned; sB <= sA;
      rA <= doRound;  rB <= rA;
      tA <= doSat;    tB <= tA;
      wA <= wideOut;  wB <= wA;
    end
  end

  // R1
  out_valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == 2'd2) |-> (outValid == vB));

  // R11
  idle_acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != 2'd0 && !outValid) |-> ($stable(accOut) && $stable(resOut)));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic [ACCW-1:0]  accL;
    logic [PRODW-1:0] resL;
    assign accL = accOut[i*ACCW +: ACCW];
    assign resL = resOut[i*PRODW +: PRODW];

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt == 2'd2 && !cB) |-> !$fell(ovfFlag[i]));

    // R8
    sat16_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt == 2'd2 && outValid && sB && tB && !wB && !rB &&
       !accL[ACCW-1] && (|accL[ACCW-2:PRODW-1]))
      |-> (resL == {{(PRODW-OPW+1){1'b0}}, {(OPW-1){1'b1}}}));

    // R9
    sat32_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt == 2'd2 && outValid && sB && tB && wB &&
       accL[ACCW-1] && !(&accL[ACCW-2:PRODW-1]))
      |-> (resL == {1'b1, {(PRODW-1){1'b0}}}));
  end

endmodule

bind dual_mac dmac_chk #(.LANES(LANES), .OPW(OPW), .GUARD(GUARD)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .isSigned (isSigned),
  .doRound  (doRound),
  .doSat    (doSat),
  .wideOut  (wideOut),
  .ovfClr   (ovfClr),
  .outValid (outValid),
  .accOut   (accOut),
  .resOut   (resOut),
  .ovfFlag  (ovfFlag)
);

// File: tb/tb_dual_mac.sv
module tb_dual_mac;

  localparam longint P31 = 64'sd2147483648;
  localparam longint P39 = 64'sd549755813888;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, isSigned = 1'b0, isFrac = 1'b0, doRound = 1'b0;
  logic        doSat = 1'b0, wideOut = 1'b0, ovfClr = 1'b0;
  logic [3:0]  laneOp = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        outValid;
  logic [79:0] accOut;
  logic [63:0] resOut;
  logic [1:0]  ovfFlag;

  always #10 clk = ~clk;   // 50 MHz

  dual_mac dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isSigned(isSigned), .isFrac(isFrac),
    .doRound(doRound), .doSat(doSat), .wideOut(wideOut), .ovfClr(ovfClr),
    .laneOp(laneOp), .opA(opA), .opB(opB), .outValid(outValid), .accOut(accOut),
    .resOut(resOut), .ovfFlag(ovfFlag)
  );

  int checks = 0;
  int errors = 0;
  int t = 0;

  // reference model state
  logic [39:0] mAcc [2];
  logic        mOvf [2];
  bit          mS = 0, mR = 0, mSat = 0, mW = 0;

  // expected results, indexed by issue cycle
  logic [39:0] eAcc [4][2];
  logic [31:0] eRes [4][2];
  logic        eOvf [4][2];
  logic        eV   [4];
  string       eTag [4];

  function automatic longint sx40(logic [39:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [39:0] fProd(logic [15:0] a, logic [15:0] b, bit sg, bit fr);
    longint x, y, p;
    x = sg ? longint'($signed(a)) : longint'(a);
    y = sg ? longint'($signed(b)) : longint'(b);
    p = x * y;
    if (fr) begin
      if (sg && a == 16'h8000 && b == 16'h8000) p = 64'h7FFFFFFF;
      else p = p * 2;
    end
    return p[39:0];
  endfunction

  function automatic logic [31:0] fRes(logic [39:0] acc, bit sg, bit rn, bit sa, bit wd);
    longint v;
    logic [15:0] h;
    v = sg ? sx40(acc) : longint'(acc);
    if (wd) begin
      if (sa && sg && v > P31 - 1) return 32'h7FFFFFFF;
      if (sa && sg && v < -P31)    return 32'h80000000;
      if (sa && !sg && v >= 2 * P31) return 32'hFFFFFFFF;
      return v[31:0];
    end
    if (rn) v = v + 32768;
    h = v[31:16];
    if (sa && sg && v > P31 - 1)   h = 16'h7FFF;
    if (sa && sg && v < -P31)      h = 16'h8000;
    if (sa && !sg && v >= 2 * P31) h = 16'hFFFF;
    return sg ? {{16{h[15]}}, h} : {16'h0000, h};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkSlot(int s);
    chk(eTag[s], "outValid(R1)", {63'd0, outValid}, {63'd0, eV[s]});
    for (int l = 0; l < 2; l++) begin
      chk(eTag[s], "acc(R4)", {24'd0, accOut[l*40 +: 40]}, {24'd0, eAcc[s][l]});
      chk(eTag[s], "res(R7)", {32'd0, resOut[l*32 +: 32]}, {32'd0, eRes[s][l]});
      chk(eTag[s], "ovf(R6)", {63'd0, ovfFlag[l]}, {63'd0, eOvf[s][l]});
    end
  endtask

  task automatic step(bit v, bit sg, bit fr, bit rn, bit sa, bit wd, bit clr,
                      logic [1:0] o0, logic [1:0] o1,
                      logic [15:0] a0, logic [15:0] b0, logic [15:0] a1, logic [15:0] b1,
                      string tag);
    logic [1:0]  ops [2];
    logic [15:0] as  [2];
    logic [15:0] bs  [2];
    @(negedge clk);
    if (t >= 2) checkSlot((t - 2) % 4);
    inValid = v; isSigned = sg; isFrac = fr; doRound = rn; doSat = sa; wideOut = wd;
    ovfClr = clr; laneOp = {o1, o0}; opA = {a1, a0}; opB = {b1, b0};
    ops[0] = o0; ops[1] = o1; as[0] = a0; as[1] = a1; bs[0] = b0; bs[1] = b1;
    for (int l = 0; l < 2; l++) begin
      logic [39:0] p;
      longint r;
      bit wrap;
      wrap = 0;
      if (v) begin
        p = fProd(as[l], bs[l], sg, fr);
        case (ops[l])
          2'b00: mAcc[l] = '0;
          2'b01: mAcc[l] = p;
          default: begin
            if (sg) r = (ops[l] == 2'b10) ? sx40(mAcc[l]) + sx40(p) : sx40(mAcc[l]) - sx40(p);
            else    r = (ops[l] == 2'b10) ? longint'(mAcc[l]) + longint'(p)
                                          : longint'(mAcc[l]) - longint'(p);
            wrap = sg ? (r > P39 - 1 || r < -P39) : (r < 0 || r >= 2 * P39);
            mAcc[l] = r[39:0];
          end
        endcase
      end
      mOvf[l] = (mOvf[l] & ~clr) | wrap;
    end
    if (v) begin mS = sg; mR = rn; mSat = sa; mW = wd; end
    for (int l = 0; l < 2; l++) begin
      eAcc[t % 4][l] = mAcc[l];
      eRes[t % 4][l] = fRes(mAcc[l], mS, mR, mSat, mW);
      eOvf[t % 4][l] = mOvf[l];
    end
    eV[t % 4] = v;
    eTag[t % 4] = tag;
    t++;
  endtask

  function automatic logic [15:0] pickOp();
    if ($urandom % 3 == 0) begin
      case ($urandom % 5)
        0: return 16'h0000;
        1: return 16'h0001;
        2: return 16'h7FFF;
        3: return 16'h8000;
        default: return 16'hFFFF;
      endcase
    end
    return 16'($urandom);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int l = 0; l < 2; l++) begin mAcc[l] = '0; mOvf[l] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "outValid", {63'd0, outValid}, 64'd0);
    chk("R10", "accOut", {48'd0, accOut[79:64]}, 64'd0);
    chk("R10", "accLow", accOut[63:0], 64'd0);
    chk("R10", "resOut", resOut, 64'd0);
    chk("R10", "ovfFlag", {62'd0, ovfFlag}, 64'd0);

    // R2 signed versus unsigned integer products
    step(1, 1, 0, 0, 0, 1, 0, 2'b01, 2'b01, 16'hFFFF, 16'h0002, 16'h8000, 16'h7FFF, "R2");
    step(1, 0, 0, 0, 0, 1, 0, 2'b01, 2'b01, 16'hFFFF, 16'h0002, 16'h8000, 16'h7FFF, "R2");
    step(1, 0, 0, 0, 0, 1, 0, 2'b01, 2'b01, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, "R2");
    // R3 fractional products and the single saturating case
    step(1, 1, 1, 0, 0, 1, 0, 2'b01, 2'b01, 16'h8000, 16'h8000, 16'h4000, 16'h4000, "R3");
    step(1, 1, 1, 0, 0, 1, 0, 2'b01, 2'b01, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h8000, "R3");
    step(1, 0, 1, 0, 0, 1, 0, 2'b01, 2'b01, 16'h8000, 16'h8000, 16'hFFFF, 16'hFFFF, "R3");
    // R4 each operation code, lanes driven differently
    step(1, 1, 0, 0, 0, 1, 0, 2'b01, 2'b00, 16'h1234, 16'h0010, 16'h7FFF, 16'h7FFF, "R4");
    step(1, 1, 0, 0, 0, 1, 0, 2'b10, 2'b11, 16'h0003, 16'h0005, 16'h0002, 16'h0009, "R4");
    step(1, 1, 0, 0, 0, 1, 0, 2'b11, 2'b10, 16'hFFF0, 16'h0004, 16'h0100, 16'h0100, "R4");
    step(1, 1, 0, 0, 0, 1, 0, 2'b00, 2'b10, 16'h5555, 16'h5555, 16'h0001, 16'h0001, "R4");

    // R5 R6 R9: signed wrap through the 40-bit limits with 32-bit clamping
    step(1, 1, 1, 0, 1, 1, 1, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R6");
    for (int k = 0; k < 262; k++)
      step(1, 1, 1, 0, 1, 1, 0, 2'b10, 2'b11, 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R6");
    step(1, 1, 0, 0, 1, 1, 0, 2'b01, 2'b01, 16'h0001, 16'h0001, 16'h0001, 16'h0001, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R6");
    // R9 32-bit clamps in signed and unsigned form
    step(1, 1, 0, 0, 1, 1, 0, 2'b01, 2'b01, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, "R9");
    for (int k = 0; k < 4; k++)
      step(1, 1, 0, 1, 1, 1, 0, 2'b10, 2'b10, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, "R9");
    step(1, 0, 0, 0, 1, 1, 0, 2'b01, 2'b01, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R9");
    step(1, 0, 0, 0, 1, 1, 0, 2'b10, 2'b11, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0001, "R9");
    // R6 unsigned carry and borrow
    step(1, 0, 1, 0, 0, 1, 1, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R6");
    for (int k = 0; k < 130; k++)
      step(1, 0, 1, 0, 1, 0, 0, 2'b10, 2'b11, 16'hFFFF, 16'hFFFF, 16'h0003, 16'h0007, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R6");

    // R7 R8 16-bit extraction around the rounding and clamping boundaries
    step(1, 1, 0, 0, 1, 0, 0, 2'b01, 2'b01, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, "R8");
    step(1, 1, 0, 1, 1, 0, 0, 2'b10, 2'b10, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, "R8");
    step(1, 1, 0, 1, 0, 0, 0, 2'b10, 2'b10, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, "R7");
    step(1, 1, 1, 1, 0, 0, 0, 2'b01, 2'b01, 16'h0001, 16'h4000, 16'h7FFF, 16'h0001, "R7");
    step(1, 1, 1, 1, 1, 0, 0, 2'b01, 2'b01, 16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF, "R8");
    step(1, 0, 0, 1, 1, 0, 0, 2'b01, 2'b01, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h0001, "R8");
    step(1, 0, 0, 1, 0, 0, 0, 2'b10, 2'b10, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h8000, "R7");

    // R11 idle cycles with busy inputs
    for (int k = 0; k < 6; k++)
      step(0, k[0], k[1], 1, 1, k[2], 0, 2'b01, 2'b11, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, "R11");

    // random mix of everything
    for (int k = 0; k < 3000; k++) begin
      bit v;
      v = ($urandom % 5) != 0;
      step(v, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 16) == 0, 2'($urandom), 2'($urandom),
           pickOp(), pickOp(), pickOp(), pickOp(), "RND");
    end

    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 16'h0, 16'h0, 16'h0, 16'h0, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule